// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block is the target end of a legacy PC-style configuration interface. A host reaches it through 8-bit I/O cycles at two adjacent addresses. The lower address is an index port and the upper one is a data port. The host first writes a register number to the index port, then reads or writes the data port to reach that register. The register space is closed after reset. A fixed key byte written to the index port opens it, and a second key byte closes it again.

Once the space is open, one global register holds a logical device number. That number picks which device bank the per-device indices reach. Six function banks carry an activate bit, two 16-bit base addresses and two interrupt selects. Their contents leave the block as parallel enable, base and interrupt-select outputs, which the function logic elsewhere on the chip uses. An auxiliary bank holds one small configuration field for each general-purpose pin. Fixed identification bytes let the host probe for the block before it programs anything.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked, `cfg_mode_o` is 0, and every activate, base, interrupt-select and pin-configuration output is 0. The logical device number and the index both reset to 0.
- R2: Writing 0x55 to the index port while locked unlocks the port one cycle later. Writing 0xAA to the index port while unlocked locks it one cycle later and leaves the stored index unchanged.
- R3: While locked, data-port writes change nothing, index-port writes other than 0x55 leave the stored index unchanged, and reads of either port return 0xFF.
- R4: The index port is at `IDX_PORT` (default 0x3F0) and the data port is at `IDX_PORT`+1. Writes to any other address are ignored, and reads of any other address, or with no read strobe, return 0x00.
- R5: While unlocked, an index-port read returns the stored index. Index 0x07 holds the logical device number, and reads return the full byte.
- R6: Index 0x20 reads 0x30 and index 0x21 reads 0x01 for every device number. Writes to these two indices are dropped.
- R7: Index 0x30 bit 0 is the activate bit of the selected bank and drives that bank's `dev_active_o` bit. It reads back as 0x00 or 0x01.
- R8: Indices 0x60 and 0x61 hold the high and low bytes of the primary base. Indices 0x62 and 0x63 hold the high and low bytes of the secondary base. Each base appears on its output slice as {high,low}.
- R9: Index 0x70 is the primary interrupt select and index 0x72 is the secondary one. Both are 8 bits wide and drive `dev_irq0_o` and `dev_irq1_o`.
- R10: Logical devices 1, 2, 3, 4, 5 and 7 map to output slots 0 through 5 in that order, and slot s uses bits [16s+15:16s] or [8s+7:8s]. Writes under any other device number except 8 are dropped, and reads under those numbers return 0x00.
- R11: Under device number 8, index 0xC0+n (n < `NGPIO`) holds pin n's configuration in bits 4:0. Bit 0 is direction (1 = input), bit 1 is polarity invert, bit 2 is combined-interrupt enable and bits 4:3 are the function select. Bits 7:5 read 0, and the field drives `gpio_cfg_o[5n+4:5n]`.
- R12: While unlocked, a read of any index that R5 through R11 do not define for the selected device number returns 0x00, and a write to such an index changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | ADDR_W | I/O address |
| io_wr_i | input | 1 | Write strobe, one cycle for each access |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational from address and state |
| cfg_mode_o | output | 1 | 1 while the port is unlocked |
| dev_active_o | output | 6 | Activate bit for each function slot |
| dev_base0_o | output | 96 | Primary base address for each slot |
| dev_base1_o | output | 96 | Secondary base address for each slot |
| dev_irq0_o | output | 48 | Primary interrupt select for each slot |
| dev_irq1_o | output | 48 | Secondary interrupt select for each slot |
| gpio_cfg_o | output | 5*NGPIO | Configuration field for each pin |

## Verification
The properties assume the host never raises the read and write strobes in the same cycle. They also assume a read strobe means a combinational sample of `io_rdata_o` and has no side effect. Every bench task drives exactly one strobe for one cycle. A reference model, kept as per-device-number arrays, predicts both the read data and the full set of parallel outputs after every access. The stimulus covers both key bytes used out of context: 0x55 written while unlocked, which is stored as a plain index, and 0xAA written while locked. It also includes a random phase that mixes unsupported device numbers, undefined indices and addresses outside the pair.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_UNLOCK   = 8'h55;
  localparam logic [7:0] KEY_LOCK     = 8'hAA;
  localparam logic [7:0] IDX_LDN      = 8'h07;
  localparam logic [7:0] IDX_ID       = 8'h20;
  localparam logic [7:0] IDX_REV      = 8'h21;
  localparam logic [7:0] IDX_ACT      = 8'h30;
  localparam logic [7:0] IDX_B0_HI    = 8'h60;
  localparam logic [7:0] IDX_B0_LO    = 8'h61;
  localparam logic [7:0] IDX_B1_HI    = 8'h62;
  localparam logic [7:0] IDX_B1_LO    = 8'h63;
  localparam logic [7:0] IDX_IRQ0     = 8'h70;
  localparam logic [7:0] IDX_IRQ1     = 8'h72;
  localparam logic [7:0] IDX_GPIO0    = 8'hC0;
  localparam logic [7:0] CHIP_ID      = 8'h30;
  localparam logic [7:0] CHIP_REV     = 8'h01;
  localparam logic [7:0] LDN_AUX      = 8'h08;
  localparam int         NUM_FN       = 6;
  localparam int         BASE_W       = 16;
  localparam int         IRQ_W        = 8;
  localparam int         GPIO_W       = 5;

  typedef struct packed {
    logic              act;
    logic [BASE_W-1:0] base0;
    logic [BASE_W-1:0] base1;
    logic [IRQ_W-1:0]  irq0;
    logic [IRQ_W-1:0]  irq1;
  } fn_regs_t;

  typedef enum logic {ST_RUN = 1'b0, ST_CFG = 1'b1} key_state_e;

  // slot 0..4 -> device 1..5, slot 5 -> device 7
  function automatic logic [7:0] fn_ldn(int slot);
    return (slot < 5) ? 8'(slot + 1) : 8'd7;
  endfunction
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       unlocked_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: if (idx_wr_i && wdata_i == KEY_UNLOCK) state_d = ST_CFG;
      ST_CFG: if (idx_wr_i && wdata_i == KEY_LOCK)   state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == ST_CFG);
endmodule

// File: rtl/cfg_fn_bank.sv
module cfg_fn_bank
  import cfg_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output fn_regs_t   regs_o,
  output logic [7:0] rdata_o
);
  fn_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      case (idx_i)
        IDX_ACT:   regs_q.act          <= wdata_i[0];
        IDX_B0_HI: regs_q.base0[15:8]  <= wdata_i;
        IDX_B0_LO: regs_q.base0[7:0]   <= wdata_i;
        IDX_B1_HI: regs_q.base1[15:8]  <= wdata_i;
        IDX_B1_LO: regs_q.base1[7:0]   <= wdata_i;
        IDX_IRQ0:  regs_q.irq0         <= wdata_i;
        IDX_IRQ1:  regs_q.irq1         <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx_i)
      IDX_ACT:   rdata_o = {7'd0, regs_q.act};
      IDX_B0_HI: rdata_o = regs_q.base0[15:8];
      IDX_B0_LO: rdata_o = regs_q.base0[7:0];
      IDX_B1_HI: rdata_o = regs_q.base1[15:8];
      IDX_B1_LO: rdata_o = regs_q.base1[7:0];
      IDX_IRQ0:  rdata_o = regs_q.irq0;
      IDX_IRQ1:  rdata_o = regs_q.irq1;
      default:   rdata_o = 8'h00;
    endcase
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/cfg_aux_bank.sv
module cfg_aux_bank
  import cfg_port_pkg::*;
#(
  parameter int NGPIO = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              idx_i,
  input  logic [7:0]              wdata_i,
  output logic [NGPIO*GPIO_W-1:0] gpio_o,
  output logic [7:0]              rdata_o
);
  logic [7:0] off;
  logic       in_range;
  logic [GPIO_W-1:0] field_q [NGPIO];
  logic [7:0] rd_mux;

  assign off      = idx_i - IDX_GPIO0;
  assign in_range = (idx_i >= IDX_GPIO0) && (off < 8'(NGPIO));

  for (genvar g = 0; g < NGPIO; g++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) field_q[g] <= '0;
      else if (wr_en_i && in_range && off == 8'(g)) field_q[g] <= wdata_i[GPIO_W-1:0];
    end
    assign gpio_o[g*GPIO_W +: GPIO_W] = field_q[g];
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NGPIO; i++)
      if (in_range && off == 8'(i)) rd_mux = {{(8-GPIO_W){1'b0}}, field_q[i]};
  end

  assign rdata_o = rd_mux;
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h03F0,
  parameter int              NGPIO    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        io_addr_i,
  input  logic                     io_wr_i,
  input  logic                     io_rd_i,
  input  logic [7:0]               io_wdata_i,
  output logic [7:0]               io_rdata_o,
  output logic                     cfg_mode_o,
  output logic [NUM_FN-1:0]        dev_active_o,
  output logic [NUM_FN*BASE_W-1:0] dev_base0_o,
  output logic [NUM_FN*BASE_W-1:0] dev_base1_o,
  output logic [NUM_FN*IRQ_W-1:0]  dev_irq0_o,
  output logic [NUM_FN*IRQ_W-1:0]  dev_irq1_o,
  output logic [NGPIO*GPIO_W-1:0]  gpio_cfg_o
);
  localparam logic [ADDR_W-1:0] DATA_PORT = IDX_PORT + 1'b1;

  logic       hit_idx, hit_data, idx_wr, data_wr, unlocked, cfg_wr;
  logic [7:0] idx_q, ldn_q, reg_rd, bank_rd, aux_rd;
  logic [7:0] fn_rd  [NUM_FN];
  logic       fn_sel [NUM_FN];

  assign hit_idx  = (io_addr_i == IDX_PORT);
  assign hit_data = (io_addr_i == DATA_PORT);
  assign idx_wr   = io_wr_i && hit_idx;
  assign data_wr  = io_wr_i && hit_data;
  assign cfg_wr   = data_wr && unlocked;

  cfg_key_fsm u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (io_wdata_i),
    .unlocked_o (unlocked)
  );

  // lock key is consumed, not stored as index
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= 8'h00;
    else if (idx_wr && unlocked && io_wdata_i != KEY_LOCK) idx_q <= io_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ldn_q <= 8'h00;
    else if (cfg_wr && idx_q == IDX_LDN) ldn_q <= io_wdata_i;
  end

  for (genvar s = 0; s < NUM_FN; s++) begin : g_fn
    fn_regs_t regs;
    assign fn_sel[s] = (ldn_q == fn_ldn(s));

    cfg_fn_bank u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (cfg_wr && fn_sel[s]),
      .idx_i   (idx_q),
      .wdata_i (io_wdata_i),
      .regs_o  (regs),
      .rdata_o (fn_rd[s])
    );

    assign dev_active_o[s]                 = regs.act;
    assign dev_base0_o[s*BASE_W +: BASE_W] = regs.base0;
    assign dev_base1_o[s*BASE_W +: BASE_W] = regs.base1;
    assign dev_irq0_o[s*IRQ_W +: IRQ_W]    = regs.irq0;
    assign dev_irq1_o[s*IRQ_W +: IRQ_W]    = regs.irq1;
  end

  cfg_aux_bank #(.NGPIO(NGPIO)) u_aux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (cfg_wr && ldn_q == LDN_AUX),
    .idx_i   (idx_q),
    .wdata_i (io_wdata_i),
    .gpio_o  (gpio_cfg_o),
    .rdata_o (aux_rd)
  );

  always_comb begin
    bank_rd = (ldn_q == LDN_AUX) ? aux_rd : 8'h00;
    for (int s = 0; s < NUM_FN; s++)
      if (fn_sel[s]) bank_rd = bank_rd | fn_rd[s];
  end

  always_comb begin
    case (idx_q)
      IDX_LDN: reg_rd = ldn_q;
      IDX_ID:  reg_rd = CHIP_ID;
      IDX_REV: reg_rd = CHIP_REV;
      default: reg_rd = bank_rd;
    endcase
  end

  always_comb begin
    io_rdata_o = 8'h00;
    if (io_rd_i) begin
      if (hit_idx)       io_rdata_o = unlocked ? idx_q  : 8'hFF;
      else if (hit_data) io_rdata_o = unlocked ? reg_rd : 8'hFF;
    end
  end

  assign cfg_mode_o = unlocked;
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk
  import cfg_port_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT = 16'h03F0,
  parameter int              NGPIO    = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        io_addr_i,
  input logic                     io_wr_i,
  input logic                     io_rd_i,
  input logic [7:0]               io_wdata_i,
  input logic [7:0]               io_rdata_o,
  input logic                     cfg_mode_o,
  input logic [NUM_FN-1:0]        dev_active_o,
  input logic [NUM_FN*BASE_W-1:0] dev_base0_o,
  input logic [NUM_FN*BASE_W-1:0] dev_base1_o,
  input logic [NUM_FN*IRQ_W-1:0]  dev_irq0_o,
  input logic [NUM_FN*IRQ_W-1:0]  dev_irq1_o,
  input logic [NGPIO*GPIO_W-1:0]  gpio_cfg_o
);
  logic on_idx, on_data;
  assign on_idx  = (io_addr_i == IDX_PORT);
  assign on_data = (io_addr_i == IDX_PORT + 1'b1);

  // R2
  a_r2_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && io_wr_i && on_idx && io_wdata_i == KEY_UNLOCK) |=> cfg_mode_o);

  a_r2_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && io_wr_i && on_idx && io_wdata_i == KEY_LOCK) |=> !cfg_mode_o);

  // R3
  a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && !(io_wr_i && on_idx && io_wdata_i == KEY_UNLOCK)) |=>
      (!cfg_mode_o && $stable(dev_active_o) && $stable(dev_base0_o) &&
       $stable(dev_base1_o) && $stable(dev_irq0_o) && $stable(dev_irq1_o) &&
       $stable(gpio_cfg_o)));

  a_r3_locked_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && io_rd_i && (on_idx || on_data)) |-> io_rdata_o == 8'hFF);

  // R4
  a_r4_miss_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!io_rd_i || !(on_idx || on_data)) |-> io_rdata_o == 8'h00);

  // R7 R11: state outputs move only after an unlocked data write
  a_r7_change_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dev_active_o) || !$stable(gpio_cfg_o)) |->
      $past(cfg_mode_o && io_wr_i && on_data));

  // R6
  a_r6_id_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && io_rd_i && on_idx && io_rdata_o == IDX_ID) |=>
      (io_rd_i && on_data && cfg_mode_o) |-> io_rdata_o == CHIP_ID);
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .NGPIO(NGPIO)
) u_chk (.*);

// File: tb/tb_keyed_cfg_port.sv
`timescale 1ns/1ps
module tb_keyed_cfg_port;
  localparam int NG = 8;
  localparam int NF = 6;
  localparam logic [15:0] PI = 16'h03F0;
  localparam logic [15:0] PD = 16'h03F1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic cfg_mode;
  logic [NF-1:0] act;
  logic [NF*16-1:0] b0, b1;
  logic [NF*8-1:0] q0, q1;
  logic [NG*5-1:0] gp;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyed_cfg_port #(.ADDR_W(16), .IDX_PORT(PI), .NGPIO(NG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(addr), .io_wr_i(wr), .io_rd_i(rd),
    .io_wdata_i(wdata), .io_rdata_o(rdata), .cfg_mode_o(cfg_mode),
    .dev_active_o(act), .dev_base0_o(b0), .dev_base1_o(b1),
    .dev_irq0_o(q0), .dev_irq1_o(q1), .gpio_cfg_o(gp)
  );

  // reference model, keyed by device number
  bit         m_locked = 1;
  logic [7:0] m_idx = 0, m_ldn = 0;
  bit         m_act [256];
  logic [15:0] m_b0 [256];
  logic [15:0] m_b1 [256];
  logic [7:0] m_q0 [256];
  logic [7:0] m_q1 [256];
  logic [4:0] m_gp [NG];

  function automatic bit is_fn(logic [7:0] l);
    return l inside {8'd1, 8'd2, 8'd3, 8'd4, 8'd5, 8'd7};
  endfunction

  function automatic logic [7:0] slot_ldn(int s);
    return (s < 5) ? 8'(s + 1) : 8'd7;
  endfunction

  function automatic void m_write(logic [15:0] a, logic [7:0] d);
    if (a == PI) begin
      if (m_locked) begin
        if (d == 8'h55) m_locked = 0;
      end else if (d == 8'hAA) m_locked = 1;
      else m_idx = d;
    end else if (a == PD && !m_locked) begin
      if (m_idx == 8'h07) m_ldn = d;
      else if (is_fn(m_ldn)) begin
        case (m_idx)
          8'h30: m_act[m_ldn] = d[0];
          8'h60: m_b0[m_ldn][15:8] = d;
          8'h61: m_b0[m_ldn][7:0] = d;
          8'h62: m_b1[m_ldn][15:8] = d;
          8'h63: m_b1[m_ldn][7:0] = d;
          8'h70: m_q0[m_ldn] = d;
          8'h72: m_q1[m_ldn] = d;
          default: ;
        endcase
      end else if (m_ldn == 8'd8 && m_idx >= 8'hC0 && int'(m_idx) < 8'hC0 + NG)
        m_gp[m_idx - 8'hC0] = d[4:0];
    end
  endfunction

  function automatic logic [7:0] m_read(logic [15:0] a);
    if (a != PI && a != PD) return 8'h00;
    if (m_locked) return 8'hFF;
    if (a == PI) return m_idx;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h30;
      8'h21: return 8'h01;
      default: ;
    endcase
    if (is_fn(m_ldn)) begin
      case (m_idx)
        8'h30: return {7'd0, m_act[m_ldn]};
        8'h60: return m_b0[m_ldn][15:8];
        8'h61: return m_b0[m_ldn][7:0];
        8'h62: return m_b1[m_ldn][15:8];
        8'h63: return m_b1[m_ldn][7:0];
        8'h70: return m_q0[m_ldn];
        8'h72: return m_q1[m_ldn];
        default: return 8'h00;
      endcase
    end
    if (m_ldn == 8'd8 && m_idx >= 8'hC0 && int'(m_idx) < 8'hC0 + NG)
      return {3'd0, m_gp[m_idx - 8'hC0]};
    return 8'h00;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic cmp_outputs();
    chk(cfg_mode == !m_locked, "R2 cfg_mode", 32'(cfg_mode), 32'(!m_locked));
    for (int s = 0; s < NF; s++) begin
      logic [7:0] l = slot_ldn(s);
      chk(act[s] == m_act[l], "R7/R10 active", 32'(act[s]), 32'(m_act[l]));
      chk(b0[s*16 +: 16] == m_b0[l], "R8/R10 base0", 32'(b0[s*16 +: 16]), 32'(m_b0[l]));
      chk(b1[s*16 +: 16] == m_b1[l], "R8/R10 base1", 32'(b1[s*16 +: 16]), 32'(m_b1[l]));
      chk(q0[s*8 +: 8] == m_q0[l], "R9/R10 irq0", 32'(q0[s*8 +: 8]), 32'(m_q0[l]));
      chk(q1[s*8 +: 8] == m_q1[l], "R9/R10 irq1", 32'(q1[s*8 +: 8]), 32'(m_q1[l]));
    end
    for (int g = 0; g < NG; g++)
      chk(gp[g*5 +: 5] == m_gp[g], "R11 gpio", 32'(gp[g*5 +: 5]), 32'(m_gp[g]));
  endtask

  task automatic io_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    #1;
    wr = 1'b0;
    m_write(a, d);
    cmp_outputs();
  endtask

  task automatic io_rd(logic [15:0] a, string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1;
    e = m_read(a);
    chk(rdata == e, req, 32'(rdata), 32'(e));
    @(posedge clk);
    #1;
    rd = 1'b0;
    cmp_outputs();
  endtask

  task automatic reg_wr(logic [7:0] i, logic [7:0] d);
    io_wr(PI, i);
    io_wr(PD, d);
  endtask

  task automatic reg_rd(logic [7:0] i, string req);
    io_wr(PI, i);
    io_rd(PD, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    for (int i = 0; i < 256; i++) begin
      m_act[i] = 0; m_b0[i] = 0; m_b1[i] = 0; m_q0[i] = 0; m_q1[i] = 0;
    end
    for (int g = 0; g < NG; g++) m_gp[g] = 0;

    repeat (3) @(posedge clk);
    #1;
    cmp_outputs();                          // R1 during reset
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    cmp_outputs();                          // R1
    io_rd(PD, "R1 locked data read");
    io_rd(PI, "R3 locked index read");

    // R3: locked writes do nothing
    io_wr(PI, 8'h07);
    io_wr(PD, 8'h01);
    io_wr(PI, 8'hAA);
    io_wr(PI, 8'h30);
    io_wr(PD, 8'h01);
    io_rd(PD, "R3 still locked");

    // R2 unlock, R1 index/ldn reset value
    io_wr(PI, 8'h55);
    io_rd(PI, "R1 index reset zero");
    reg_rd(8'h07, "R1 ldn reset zero");
    reg_rd(8'h20, "R6 id");
    reg_rd(8'h21, "R6 rev");
    reg_wr(8'h20, 8'h99);
    reg_rd(8'h20, "R6 id write dropped");
    reg_wr(8'h21, 8'h77);
    reg_rd(8'h21, "R6 rev write dropped");

    // program every function bank with its own pattern
    for (int s = 0; s < NF; s++) begin
      logic [7:0] l = slot_ldn(s);
      reg_wr(8'h07, l);
      reg_rd(8'h07, "R5 ldn readback");
      reg_wr(8'h30, 8'hFE | 8'(s & 1));
      reg_rd(8'h30, "R7 activate readback");
      reg_wr(8'h60, 8'h10 + 8'(s));
      reg_wr(8'h61, 8'hA0 + 8'(s));
      reg_wr(8'h62, 8'h30 + 8'(s));
      reg_wr(8'h63, 8'hC5 - 8'(s));
      reg_wr(8'h70, 8'h0E - 8'(s));
      reg_wr(8'h72, 8'h80 | 8'(s));
      reg_rd(8'h61, "R8 base0 lo");
      reg_rd(8'h62, "R8 base1 hi");
      reg_rd(8'h72, "R9 irq1");
      reg_rd(8'h31, "R12 undefined index");
      reg_wr(8'h71, 8'h5A);
      reg_wr(8'h64, 8'h5A);
    end
    reg_wr(8'h07, 8'd7);
    reg_wr(8'h30, 8'h01);
    reg_rd(8'h30, "R7 keyboard slot active");

    // R10 unsupported device numbers
    foreach (m_act[i]) if (i inside {0, 6, 9, 255}) begin
      reg_wr(8'h07, 8'(i));
      reg_wr(8'h30, 8'h01);
      reg_wr(8'h60, 8'hDE);
      reg_wr(8'h70, 8'h0F);
      reg_rd(8'h60, "R10 unsupported read");
      reg_rd(8'h30, "R10 unsupported act read");
    end

    // R11 aux bank
    reg_wr(8'h07, 8'd8);
    for (int g = 0; g < NG; g++) begin
      reg_wr(8'hC0 + 8'(g), 8'hE0 | 8'(g * 3));
      reg_rd(8'hC0 + 8'(g), "R11 gpio readback");
    end
    reg_wr(8'h30, 8'h01);
    reg_rd(8'h30, "R12 act index in aux bank");
    reg_rd(8'hC0 + 8'(NG), "R12 past last gpio");
    reg_rd(8'hBF, "R12 below gpio");

    // R4 other addresses
    io_wr(16'h03F2, 8'h07);
    io_wr(16'h13F1, 8'h33);
    io_rd(PI, "R4 index unchanged");
    io_rd(16'h03F2, "R4 miss read");
    io_rd(16'h02F0, "R4 miss read 2");

    // 0x55 while unlocked is a plain index
    io_wr(PI, 8'h55);
    io_rd(PI, "R2 0x55 as index");
    io_wr(PD, 8'h12);
    io_rd(PD, "R12 index 0x55 reads zero");

    // R2 lock keeps the index
    io_wr(PI, 8'h07);
    io_wr(PI, 8'hAA);
    io_rd(PD, "R3 locked after AA");
    io_wr(PI, 8'h55);
    io_rd(PI, "R2 index kept across lock");

    // random phase
    for (int k = 0; k < 1500; k++) begin
      int op = int'($urandom_range(0, 9));
      logic [7:0] v;
      case ($urandom_range(0, 7))
        0: v = 8'h07;
        1: v = 8'h30;
        2: v = 8'h60 + 8'($urandom_range(0, 3));
        3: v = 8'h70 + 8'($urandom_range(0, 2));
        4: v = 8'hC0 + 8'($urandom_range(0, NG));
        5: v = 8'($urandom_range(0, 9));
        6: v = ($urandom_range(0, 15) == 0) ? 8'hAA : 8'h55;
        default: v = 8'($urandom);
      endcase
      case (op)
        0, 1, 2: io_wr(PI, v);
        3, 4, 5: io_wr(PD, v);
        6: io_rd(PI, "R5 random index read");
        7, 8: io_rd(PD, "R12 random data read");
        default: io_wr(16'h03F0 + 16'($urandom_range(2, 5)), v);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule